// File: doc/BRIEF.md
# Task Priority Interrupt Gate

This block decides whether an external interrupt vector may be delivered. It holds a 4-bit priority threshold in a privileged control register. Each incoming vector gets a priority class, which is the upper nibble of its 8-bit number. The vector goes through only when its class is strictly greater than the threshold. The gate is combinational on the registered threshold, so a new threshold governs delivery from the clock edge that stores it onward. A pending interrupt that one write unblocks can therefore be taken before a following write raises the threshold again.

The register is reached through a 64-bit read/write port that also carries the requester's current privilege level. Only level 0 may read or write it. Any other level, and any write that puts ones in the reserved upper bits, raises a one-cycle protection-fault pulse and leaves the register unchanged. Choosing among several pending sources is done upstream; this block sees one pending vector at a time.

Top module: `tpr_gate`

## Requirements
- R1: The priority class of a vector is `vec_num[7:4]`. In the same cycle, `irq_req` is 1 exactly when `vec_valid` is 1 and that class is greater than the stored threshold. `irq_vec` equals `vec_num` while `irq_req` is 1 and is 0 otherwise.
- R2: With threshold N, every class at or below N is held back. A class-0 vector is never delivered.
- R3: A threshold of 0 delivers every class from 1 to 15. A threshold of 15 delivers nothing.
- R4: While `rst_n` is low, the threshold is 0 and `reg_rdata` and `gp_fault` are 0.
- R5: A write with `cur_pl` = 0 and `reg_wdata[63:4]` = 0 stores `reg_wdata[3:0]` at the clock edge. Gating uses the new value from that edge onward.
- R6: A read with `cur_pl` = 0 puts the threshold, zero-extended to 64 bits, on `reg_rdata` for the cycle after the request edge. In every other cycle `reg_rdata` is 0, and bits 63:4 are always 0.
- R7: A read or write with `cur_pl` other than 0 raises `gp_fault` for one cycle after the request edge. The threshold is not changed and no data is returned.
- R8: A level-0 write with any nonzero bit in `reg_wdata[63:4]` raises `gp_fault` for one cycle and leaves the threshold unchanged.
- R9: Consider two back-to-back writes, first a low threshold and then a high one. A vector whose class lies between the two is delivered during the cycle between the two writes.
- R10: When a read and a granted write occur in the same cycle, the read returns the threshold held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_valid | input | 1 | Pending vector present |
| vec_num | input | 8 | Pending vector number |
| irq_req | output | 1 | Gated interrupt request |
| irq_vec | output | 8 | Vector delivered with the request, 0 when none |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_wdata | input | 64 | Write data |
| cur_pl | input | 2 | Privilege level of the requester |
| reg_rdata | output | 64 | Read data, valid the cycle after a granted read |
| gp_fault | output | 1 | Protection-fault pulse |

## Verification
The assertions assume that `cur_pl` and the request strobes are settled at each rising edge. They also assume that the threshold can change only through the write port, so any change in it must trace back to a granted level-0 write one edge earlier. The bench meets these assumptions by changing every input on the falling edge, never between a falling edge and the next rising edge. It samples the combinational gate shortly after the inputs change. It reads the registered read data and fault outputs on the falling edge that follows the request edge.

// File: rtl/tpr_gate.sv
module tpr_gate #(
  parameter int DATA_W  = 64,
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4,
  parameter int PL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_valid,
  input  logic [VEC_W-1:0]  vec_num,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [PL_W-1:0]   cur_pl,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              gp_fault
);
  localparam int RSV_W = DATA_W - CLASS_W;

  logic [CLASS_W-1:0] thr;
  logic [CLASS_W-1:0] vec_class;

  assign vec_class = vec_num[VEC_W-1 -: CLASS_W];

  wire priv_ok   = (cur_pl == '0);
  wire rsv_clean = (reg_wdata[DATA_W-1:CLASS_W] == '0);
  wire wr_ok     = reg_wr && priv_ok && rsv_clean;
  wire rd_ok     = reg_rd && priv_ok;
  wire fault_now = ((reg_wr || reg_rd) && !priv_ok) || (reg_wr && priv_ok && !rsv_clean);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr       <= '0;
      reg_rdata <= '0;
      gp_fault  <= 1'b0;
    end else begin
      if (wr_ok) thr <= reg_wdata[CLASS_W-1:0];
      reg_rdata <= rd_ok ? {{RSV_W{1'b0}}, thr} : '0;
      gp_fault  <= fault_now;
    end
  end

  assign irq_req = vec_valid && (vec_class > thr);
  assign irq_vec = irq_req ? vec_num : '0;

  // R2
  property class0_blocked_p;
    @(posedge clk) disable iff (!rst_n) irq_req |-> (vec_num[VEC_W-1 -: CLASS_W] != '0);
  endproperty
  class0_blocked_chk: assert property (class0_blocked_p);

  // R5
  property thr_update_p;
    @(posedge clk) disable iff (!rst_n) (thr != $past(thr)) |-> $past(reg_wr && cur_pl == '0);
  endproperty
  thr_update_chk: assert property (thr_update_p);

  // R7
  property fault_hold_p;
    @(posedge clk) disable iff (!rst_n) gp_fault |-> ($stable(thr) && reg_rdata == '0);
  endproperty
  fault_hold_chk: assert property (fault_hold_p);

  // R7
  property fault_cause_p;
    @(posedge clk) disable iff (!rst_n) gp_fault |-> $past(reg_wr || reg_rd);
  endproperty
  fault_cause_chk: assert property (fault_cause_p);

  // R6
  property rdata_rsv_p;
    @(posedge clk) disable iff (!rst_n) reg_rdata[DATA_W-1:CLASS_W] == '0;
  endproperty
  rdata_rsv_chk: assert property (rdata_rsv_p);

  // R1
  property irq_vec_p;
    @(posedge clk) disable iff (!rst_n) !irq_req |-> (irq_vec == '0);
  endproperty
  irq_vec_chk: assert property (irq_vec_p);
endmodule

// File: tb/tpr_gate_tb_top.sv
module tpr_gate_tb_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vec_valid = 1'b0;
  logic [7:0]  vec_num = '0;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [1:0]  cur_pl = '0;
  logic [63:0] reg_rdata;
  logic        gp_fault;

  int tests = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  tpr_gate dut_i (
    .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_num(vec_num),
    .irq_req(irq_req), .irq_vec(irq_vec), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .cur_pl(cur_pl), .reg_rdata(reg_rdata), .gp_fault(gp_fault)
  );

  // {threshold[3:0], vector[7:0], expected request}
  localparam logic [12:0] TBL [16] = '{
    {4'd0,  8'h53, 1'b1}, {4'd0,  8'h0E, 1'b0}, {4'd0,  8'h10, 1'b1}, {4'd4,  8'h53, 1'b1},
    {4'd5,  8'h53, 1'b0}, {4'd5,  8'h5F, 1'b0}, {4'd5,  8'h60, 1'b1}, {4'd9,  8'h9A, 1'b0},
    {4'd9,  8'hA0, 1'b1}, {4'd15, 8'hFF, 1'b0}, {4'd15, 8'hF0, 1'b0}, {4'd14, 8'hF3, 1'b1},
    {4'd7,  8'h81, 1'b1}, {4'd8,  8'h81, 1'b0}, {4'd3,  8'h2C, 1'b0}, {4'd2,  8'h30, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [63:0] d, input logic [1:0] pl);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d; cur_pl = pl;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; cur_pl = '0;
  endtask

  task automatic do_rd(input logic [1:0] pl);
    @(negedge clk);
    reg_rd = 1'b1; cur_pl = pl;
    @(negedge clk);
    reg_rd = 1'b0; cur_pl = '0;
  endtask

  task automatic gate_chk(input logic [7:0] v, input bit exp, input string req);
    vec_valid = 1'b1; vec_num = v;
    #1;
    check(irq_req == exp, req, {63'd0, irq_req}, {63'd0, exp});
    check(irq_vec == (exp ? v : 8'h00), req, {56'd0, irq_vec}, {56'd0, (exp ? v : 8'h00)});
    vec_valid = 1'b0; vec_num = '0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4: reset state
    check(reg_rdata == '0, "R4", reg_rdata, 0);
    check(gp_fault == 1'b0, "R4", {63'd0, gp_fault}, 0);
    rst_n = 1'b1;
    do_rd(2'd0);
    check(reg_rdata == 64'd0, "R4", reg_rdata, 0);
    gate_chk(8'h53, 1'b1, "R4");

    // R1 R2 R3 R5: table walk
    for (int i = 0; i < 16; i++) begin
      do_wr({60'd0, TBL[i][12:9]}, 2'd0);
      gate_chk(TBL[i][8:1], TBL[i][0], "R1_R2_R3_R5");
    end

    // R1: vec_valid low never requests
    do_wr(64'd0, 2'd0);
    vec_valid = 1'b0; vec_num = 8'hF7; #1;
    check(irq_req == 1'b0 && irq_vec == 8'h00, "R1", {63'd0, irq_req}, 0);

    // R6: granted read
    do_wr(64'd11, 2'd0);
    do_rd(2'd0);
    check(reg_rdata == 64'd11, "R6", reg_rdata, 11);
    @(negedge clk);
    check(reg_rdata == 64'd0, "R6", reg_rdata, 0);

    // R7: privileged read and write refused
    for (int pl = 1; pl < 4; pl++) begin
      do_wr(64'd2, pl[1:0]);
      check(gp_fault == 1'b1, "R7", {63'd0, gp_fault}, 1);
      do_rd(pl[1:0]);
      check(gp_fault == 1'b1, "R7", {63'd0, gp_fault}, 1);
      check(reg_rdata == 64'd0, "R7", reg_rdata, 0);
    end
    @(negedge clk);
    check(gp_fault == 1'b0, "R7", {63'd0, gp_fault}, 0);
    gate_chk(8'hB0, 1'b0, "R7");
    do_rd(2'd0);
    check(reg_rdata == 64'd11, "R7", reg_rdata, 11);

    // R8: reserved bits set
    do_wr(64'h10, 2'd0);
    check(gp_fault == 1'b1, "R8", {63'd0, gp_fault}, 1);
    do_wr(64'h8000_0000_0000_0003, 2'd0);
    check(gp_fault == 1'b1, "R8", {63'd0, gp_fault}, 1);
    gate_chk(8'hB0, 1'b0, "R8");
    do_rd(2'd0);
    check(reg_rdata == 64'd11, "R8", reg_rdata, 11);

    // R9: low then high write, vector taken in between
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 64'd2; cur_pl = 2'd0;
    @(negedge clk);
    reg_wdata = 64'd9;
    vec_valid = 1'b1; vec_num = 8'h55; #1;
    check(irq_req == 1'b1, "R9", {63'd0, irq_req}, 1);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; #1;
    check(irq_req == 1'b0, "R9", {63'd0, irq_req}, 0);
    vec_valid = 1'b0; vec_num = '0;

    // R10: read and write together return old value
    @(negedge clk);
    reg_wr = 1'b1; reg_rd = 1'b1; reg_wdata = 64'd4;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    check(reg_rdata == 64'd9, "R10", reg_rdata, 9);
    do_rd(2'd0);
    check(reg_rdata == 64'd4, "R10", reg_rdata, 4);

    // R4: reset clears threshold
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    gate_chk(8'h10, 1'b1, "R4");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule